// File: doc/BRIEF.md
# Bit-Serial Adder with Sequencing Controller

This block adds two 8-bit unsigned operands using a single full-adder cell and a one-bit carry store. It spends one clock per bit, so it trades speed for a very small datapath. Each operand lives in its own right-shifting register. A two-way input selector in front of each register picks either a parallel load word or the serial path. During an addition the lowest bit of each register feeds the adder. The sum bit is shifted into the top of the first register. The second register rotates its own outgoing bit back into its top, so it ends unchanged.

Software or a neighbouring block first writes the operands through the load strobes while the block is idle. It then raises the start request. After eight shift cycles the block shows a one-cycle completion pulse. At that point the first register holds the sum and the carry output holds the ninth sum bit. The carry stays readable until the next addition is accepted. A start request that is still high at completion cannot launch a second addition. It must first be seen low.

Top module: `bitser_adder`

## Requirements
- R1: While reset is asserted, and right after it, both registers read 0, busy and done are 0 and the carry output is 0. An asserted reset aborts an addition that is in progress.
- R2: While idle with start low, a high load strobe copies its data word into the matching register at the next rising edge.
- R3: An accepted start is followed by exactly 8 cycles with busy high. Then comes exactly one cycle with done high and busy low, and after that the block is idle. Busy and done are never high together.
- R4: While done is high, operand register A holds the low 8 bits of the sum of the two operands present when start was accepted.
- R5: While done is high, operand register B holds the same value it had when start was accepted.
- R6: While done is high, the carry output equals bit 8 of the 9-bit sum. It keeps that value while idle, until the next start is accepted.
- R7: A load strobe is ignored while busy, in the done cycle, and in the same cycle as an accepted start.
- R8: If start is still high when done is reached, no new addition begins until start has been low for at least one cycle.
- R9: The stored carry is cleared when a start is accepted, so a carry of 1 left by the previous addition does not enter the next one.
- R10: Bits are processed LSB first. After k shift cycles, register A reads {sum[k-1:0], A[7:k]} and register B reads {B[k-1:0], B[7:k]}, both in terms of the starting values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal two-stage synchronizer |
| start_i | input | 1 | Start request, level sampled; needs a low level before each new acceptance |
| load_a_i | input | 1 | Parallel load strobe for operand register A |
| load_b_i | input | 1 | Parallel load strobe for operand register B |
| data_a_i | input | 8 | Parallel load word for register A |
| data_b_i | input | 8 | Parallel load word for register B |
| reg_a_o | output | 8 | Contents of register A (the sum after completion) |
| reg_b_o | output | 8 | Contents of register B |
| busy_o | output | 1 | High during the 8 shift cycles |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Stored carry; the final carry out after completion |

## Verification
The checker captures both operands in the first busy cycle. This assumes the stimulus never changes the registers between acceptance and that cycle, and the design guarantees this by ignoring loads in the acceptance cycle. The load property only covers cycles where start is low. The reason is that a start and a load in the same idle cycle are resolved in favour of start. The bench drives every input at the falling edge and releases reset on a falling edge. It waits for the internal reset synchronizer to clear before it loads anything.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bitser_shreg.sv
module bitser_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             sel_par_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] q_d;

  // selector: 1 = parallel word, 0 = shift right with serial bit at the MSB
  always_comb begin
    if (sel_par_i) q_d = par_i;
    else           q_d = {ser_i, q_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (en_i) q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/bitser_fa_cell.sv
module bitser_fa_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic carry_q_o
);

  logic carry_q;
  logic carry_nxt;

  always_comb begin
    sum_o     = a_i ^ b_i ^ carry_q;
    carry_nxt = (a_i & b_i) | (a_i & carry_q) | (b_i & carry_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     carry_q <= 1'b0;
    else if (clr_i) carry_q <= 1'b0;
    else if (en_i)  carry_q <= carry_nxt;
  end

  assign carry_q_o = carry_q;

endmodule

// File: rtl/bitser_ctrl.sv
module bitser_ctrl
  import bitser_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic load_a_i,
  input  logic load_b_i,
  output logic shift_a_o,
  output logic shift_b_o,
  output logic sel_a_o,
  output logic sel_b_o,
  output logic clr_carry_o,
  output logic carry_en_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

  seq_state_e       state_q, state_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q;
  logic             clr_cnt;
  logic             cnt_inc;

  always_comb begin
    state_d     = state_q;
    armed_d     = armed_q;
    sel_a_o     = 1'b1;
    sel_b_o     = 1'b1;
    shift_a_o   = 1'b0;
    shift_b_o   = 1'b0;
    clr_carry_o = 1'b0;
    clr_cnt     = 1'b0;
    cnt_inc     = 1'b0;
    carry_en_o  = 1'b0;
    if (!start_i) armed_d = 1'b1;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i && armed_q) begin
          state_d     = SEQ_RUN;
          armed_d     = 1'b0;
          clr_carry_o = 1'b1;
          clr_cnt     = 1'b1;
          sel_a_o     = 1'b0;
          sel_b_o     = 1'b0;
        end else begin
          shift_a_o = load_a_i;
          shift_b_o = load_b_i;
        end
      end
      SEQ_RUN: begin
        sel_a_o    = 1'b0;
        sel_b_o    = 1'b0;
        shift_a_o  = 1'b1;
        shift_b_o  = 1'b1;
        carry_en_o = 1'b1;
        cnt_inc    = 1'b1;
        if (cnt_q == LAST_BIT) state_d = SEQ_DONE;
      end
      SEQ_DONE: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      armed_q <= 1'b1;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_cnt) cnt_q <= '0;
    else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
  end

  assign busy_o = (state_q == SEQ_RUN);
  assign done_o = (state_q == SEQ_DONE);

endmodule

// File: rtl/bitser_adder.sv
module bitser_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             load_a_i,
  input  logic             load_b_i,
  input  logic [WIDTH-1:0] data_a_i,
  input  logic [WIDTH-1:0] data_b_i,
  output logic [WIDTH-1:0] reg_a_o,
  output logic [WIDTH-1:0] reg_b_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             carry_o
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       shift_a, shift_b, sel_a, sel_b;
  logic       clr_carry, carry_en, sum_bit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  bitser_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .load_a_i   (load_a_i),
    .load_b_i   (load_b_i),
    .shift_a_o  (shift_a),
    .shift_b_o  (shift_b),
    .sel_a_o    (sel_a),
    .sel_b_o    (sel_b),
    .clr_carry_o(clr_carry),
    .carry_en_o (carry_en),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  bitser_fa_cell u_fa (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (clr_carry),
    .en_i     (carry_en),
    .a_i      (reg_a_o[0]),
    .b_i      (reg_b_o[0]),
    .sum_o    (sum_bit),
    .carry_q_o(carry_o)
  );

  bitser_shreg #(.WIDTH(WIDTH)) u_reg_a (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (shift_a),
    .sel_par_i(sel_a),
    .par_i    (data_a_i),
    .ser_i    (sum_bit),
    .q_o      (reg_a_o)
  );

  bitser_shreg #(.WIDTH(WIDTH)) u_reg_b (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (shift_b),
    .sel_par_i(sel_b),
    .par_i    (data_b_i),
    .ser_i    (reg_b_o[0]),
    .q_o      (reg_b_o)
  );

endmodule

// File: rtl/bitser_adder_chk.sv
module bitser_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             load_a_i,
  input logic [WIDTH-1:0] data_a_i,
  input logic [WIDTH-1:0] reg_a_o,
  input logic [WIDTH-1:0] reg_b_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             carry_o
);

  localparam int RC_W = $clog2(WIDTH + 2);

  logic             busy_d;
  logic [RC_W-1:0]  run_cnt;
  logic [WIDTH-1:0] a_snap, b_snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_d  <= 1'b0;
      run_cnt <= '0;
      a_snap  <= '0;
      b_snap  <= '0;
    end else begin
      busy_d <= busy_o;
      if (busy_o && !busy_d) begin
        run_cnt <= RC_W'(1);
        a_snap  <= reg_a_o;
        b_snap  <= reg_b_o;
      end else if (busy_o) begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  assert_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> run_cnt == RC_W'(WIDTH));

  assert_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> {carry_o, reg_a_o} == ({1'b0, a_snap} + {1'b0, b_snap}));

  assert_b_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> reg_b_o == b_snap);

  assert_carry_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(carry_o));

  assert_load_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && load_a_i && !start_i) |=> reg_a_o == $past(data_a_i));

endmodule

bind bitser_adder bitser_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .load_a_i(load_a_i),
  .data_a_i(data_a_i),
  .reg_a_o (reg_a_o),
  .reg_b_o (reg_b_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .carry_o (carry_o)
);

// File: tb/bitser_adder_tb.sv
`timescale 1ns/1ps
module bitser_adder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       load_a_i = 1'b0;
  logic       load_b_i = 1'b0;
  logic [7:0] data_a_i = '0;
  logic [7:0] data_b_i = '0;
  logic [7:0] reg_a_o, reg_b_o;
  logic       busy_o, done_o, carry_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  bitser_adder #(.WIDTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_a_i(load_a_i), .load_b_i(load_b_i),
    .data_a_i(data_a_i), .data_b_i(data_b_i),
    .reg_a_o(reg_a_o), .reg_b_o(reg_b_o),
    .busy_o(busy_o), .done_o(done_o), .carry_o(carry_o)
  );

  localparam int NVEC = 11;
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h00, 8'h00}, {8'h01, 8'h01}, {8'hFF, 8'h01}, {8'h00, 8'h00},
    {8'h55, 8'hAA}, {8'hFF, 8'hFF}, {8'h80, 8'h80}, {8'h3C, 8'h0F},
    {8'h7F, 8'h01}, {8'hA5, 8'h5A}, {8'h12, 8'h34}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_add(input logic [7:0] a, input logic [7:0] b,
                         input bit hold, input bit junk_run, input bit junk_start);
    logic [8:0] exp;
    exp = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    start_i = 1'b0; load_a_i = 1'b1; load_b_i = 1'b1; data_a_i = a; data_b_i = b;
    @(negedge clk);
    chk(reg_a_o == a, "R2 load A", reg_a_o, a);
    chk(reg_b_o == b, "R2 load B", reg_b_o, b);
    load_a_i = 1'b0; load_b_i = 1'b0;
    start_i = 1'b1;
    if (junk_start) begin
      load_a_i = 1'b1; load_b_i = 1'b1; data_a_i = 8'hEE; data_b_i = 8'hEE;
    end
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      case (k)
        1: begin
          if (!hold) start_i = 1'b0;
          load_a_i = 1'b0; load_b_i = 1'b0;
          chk(busy_o && !done_o, "R3 busy after start", {busy_o, done_o}, 2'b10);
        end
        3: if (junk_run) begin
          load_a_i = 1'b1; load_b_i = 1'b1; data_a_i = 8'hC3; data_b_i = 8'hC3;
        end
        4: begin load_a_i = 1'b0; load_b_i = 1'b0; end
        5: begin
          chk(reg_a_o == {exp[3:0], a[7:4]}, "R10 A mid-run", reg_a_o, {exp[3:0], a[7:4]});
          chk(reg_b_o == {b[3:0], b[7:4]}, "R10 B mid-run", reg_b_o, {b[3:0], b[7:4]});
        end
        8: chk(busy_o && !done_o, "R3 busy in 8th cycle", {busy_o, done_o}, 2'b10);
        9: begin
          chk(done_o && !busy_o, "R3 done pulse", {busy_o, done_o}, 2'b01);
          chk(reg_a_o == exp[7:0], "R4 sum in A (R7 R9)", reg_a_o, exp[7:0]);
          chk(reg_b_o == b, "R5 B kept", reg_b_o, b);
          chk(carry_o == exp[8], "R6 carry at done", carry_o, exp[8]);
          if (junk_run) begin
            load_a_i = 1'b1; load_b_i = 1'b1; data_a_i = 8'hC3; data_b_i = 8'hC3;
          end
        end
        10: begin
          load_a_i = 1'b0; load_b_i = 1'b0;
          chk(!done_o && !busy_o, "R3 idle after done", {busy_o, done_o}, 2'b00);
          chk(carry_o == exp[8], "R6 carry held", carry_o, exp[8]);
          chk(reg_a_o == exp[7:0], "R7 A after done-cycle load", reg_a_o, exp[7:0]);
          chk(reg_b_o == b, "R7 B after done-cycle load", reg_b_o, b);
        end
        default: ;
      endcase
    end
    if (hold) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk(!busy_o && !done_o, "R8 no restart while start held", {busy_o, done_o}, 2'b00);
      end
      start_i = 1'b0;
    end
  endtask

  initial begin
    #1;
    chk(reg_a_o == 8'h00 && reg_b_o == 8'h00, "R1 regs in reset", {reg_a_o, reg_b_o}, 16'h0);
    chk(!busy_o && !done_o && !carry_o, "R1 flags in reset", {busy_o, done_o, carry_o}, 3'b000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(reg_a_o == 8'h00 && reg_b_o == 8'h00, "R1 regs after reset", {reg_a_o, reg_b_o}, 16'h0);
    chk(!busy_o && !done_o && !carry_o, "R1 flags after reset", {busy_o, done_o, carry_o}, 3'b000);

    for (int i = 0; i < NVEC; i++)
      run_add(VEC[i][15:8], VEC[i][7:0], 1'b0, i[0], 1'b0);

    // load on the acceptance cycle is ignored
    run_add(8'h10, 8'h20, 1'b0, 1'b0, 1'b1);
    // start held high through completion
    run_add(8'hF0, 8'h1F, 1'b1, 1'b0, 1'b0);
    // after start went low, a new start is accepted; R9 carry cleared after carry=1
    run_add(8'h01, 8'h02, 1'b0, 1'b0, 1'b0);

    // R1: reset aborts an addition in progress
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy_o && !done_o && !carry_o, "R1 mid-run reset flags", {busy_o, done_o, carry_o}, 3'b000);
    chk(reg_a_o == 8'h00 && reg_b_o == 8'h00, "R1 mid-run reset regs", {reg_a_o, reg_b_o}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_add(8'h99, 8'h77, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule